// File: doc/BRIEF.md
# Four-Level Nesting Interrupt Arbiter

This block sits between twelve interrupt flag sources and a processor core. Each source has its own enable and a shared global enable, and a two-bit priority level built from a high bit and a low bit. Every cycle the block finds the source that should be taken next. That source must sit at a level strictly above every level now in service. Among the sources at the highest such level, a fixed ranking picks the winner. The winner is offered to the core as a held valid/ready transfer that carries the source index, its level and its vector address.

When the core accepts an offer, the block pulses a one-hot acknowledge back to the winning source so that its flag can be cleared. It also marks the winner's level as in service. A return strobe retires the highest level in service, so nested routines unwind in order. A separate wakeup output tells power management when an enabled source that may end power-down has its flag up.

Back-pressure rules: once `irq_valid_o` is high, the source, level and vector stay frozen until `irq_ready_i` is seen high at a clock edge, whatever the flags do in the meantime. After each accepted transfer, `irq_valid_o` is low for at least one cycle. A new offer is loaded only while no offer is held.

Top module: `lvl4_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid_o` is 0, `active_o` is 0 and `ack_o` is 0.
- R2: A source takes part in arbitration only when its flag, its own enable bit and `glob_en_i` are all 1.
- R3: A source's level is {prio_hi_i[s], prio_lo_i[s]} (3 highest, 0 lowest). A source is eligible only when its level is strictly above the highest set bit of `active_o`; any level is eligible when `active_o` is 0. Among eligible sources the highest level wins.
- R4: Ties within one level are broken by this order, first wins: 0, 5, 9, 1, 6, 2, 7, 10, 3, 8, 4, 11.
- R5: `irq_vec_o` for source s is 0x0003 + 8*s for s = 0..8, and 0x0053, 0x0063 and 0x0073 for s = 9, 10 and 11. `irq_src_o` is s and `irq_lvl_o` is the winner's level.
- R6: With no offer held, an eligible source raises `irq_valid_o` at the next clock edge. While `irq_valid_o` is 1 and `irq_ready_i` is 0, source, level and vector hold their values.
- R7: In a cycle where `irq_valid_o` and `irq_ready_i` are both 1, `ack_o` is one-hot at bit `irq_src_o` (otherwise 0). At that edge the winner's level bit is set in `active_o`, and `irq_valid_o` is 0 in the following cycle.
- R8: `reti_i` clears the highest set bit of `active_o` at the clock edge. If an accepted transfer and `reti_i` fall in the same cycle, the old highest bit is cleared and the new level's bit is set.
- R9: Source 4 (serial) requests when `ser_tx_i` or `ser_rx_i` is 1. `flag_i[4]` is ignored.
- R10: `wake_o` is 1 exactly when some source in {0, 2, 5, 7, 8, 9, 10} has its flag and its own enable at 1, regardless of `glob_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | 12 | Per-source request flags (bit 4 unused) |
| ser_tx_i | input | 1 | Serial transmit flag |
| ser_rx_i | input | 1 | Serial receive flag |
| en_i | input | 12 | Per-source enables |
| glob_en_i | input | 1 | Global enable |
| prio_hi_i | input | 12 | Per-source priority high bit |
| prio_lo_i | input | 12 | Per-source priority low bit |
| irq_valid_o | output | 1 | Offer held |
| irq_ready_i | input | 1 | Core accepts offer |
| irq_src_o | output | 4 | Offered source index |
| irq_lvl_o | output | 2 | Offered source level |
| irq_vec_o | output | 16 | Offered vector address |
| ack_o | output | 12 | One-hot acknowledge to the accepted source |
| reti_i | input | 1 | Return strobe, retires highest active level |
| active_o | output | 4 | In-service levels |
| wake_o | output | 1 | Power-down wakeup request |

## Verification
The hardest case to reach is nested service with a strictly-higher-only preemption rule. It needs one level already in service when a competitor arrives at the same level, at a higher level and at the top level. It also needs an offer that is accepted in the same cycle as a return. The bench builds these cases by serving one source, leaving its level active, and then raising the next flag. The tie-break ranking is covered by sweeping every pair of sources, once at a shared level and once at differing levels.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int NUM_SRC    = 12;
  localparam int LVL_W      = 2;
  localparam int NUM_LVL    = 1 << LVL_W;
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int VEC_W      = 16;
  localparam int SERIAL_SRC = 4;

  // sources allowed to end power-down: 0,2,5,7,8,9,10
  localparam logic [NUM_SRC-1:0] WAKE_MASK = 12'b0111_1010_0101;

  function automatic logic [VEC_W-1:0] vector_of(input logic [SRC_W-1:0] s);
    logic [VEC_W-1:0] v;
    case (s)
      4'd9:    v = 16'h0053;
      4'd10:   v = 16'h0063;
      4'd11:   v = 16'h0073;
      default: v = 16'h0003 + (VEC_W'(s) << 3);
    endcase
    return v;
  endfunction

  // source index holding tie-break position p (0 = first)
  function automatic logic [SRC_W-1:0] src_at_rank(input int p);
    logic [SRC_W-1:0] s;
    case (p)
      0:       s = 4'd0;
      1:       s = 4'd5;
      2:       s = 4'd9;
      3:       s = 4'd1;
      4:       s = 4'd6;
      5:       s = 4'd2;
      6:       s = 4'd7;
      7:       s = 4'd10;
      8:       s = 4'd3;
      9:       s = 4'd8;
      10:      s = 4'd4;
      default: s = 4'd11;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lic_src_level.sv
module lic_src_level
  import lic_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glob_en_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic [NUM_SRC-1:0] prio_lo_i,
  output logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic             pend;
    logic [LVL_W-1:0] lvl;
    assign pend = req_i[s] & en_i[s] & glob_en_i;
    assign lvl  = {prio_hi_i[s], prio_lo_i[s]};
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign lvl_mask_o[l][s] = pend && (lvl == LVL_W'(l));
    end
  end
endmodule

// File: rtl/lic_rank_pick.sv
module lic_rank_pick
  import lic_pkg::*;
(
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               found_o,
  output logic [SRC_W-1:0]   src_o
);
  always_comb begin
    found_o = 1'b0;
    src_o   = '0;
    for (int p = NUM_SRC - 1; p >= 0; p--) begin
      if (mask_i[src_at_rank(p)]) begin
        found_o = 1'b1;
        src_o   = src_at_rank(p);
      end
    end
  end
endmodule

// File: rtl/lic_level_arb.sv
module lic_level_arb
  import lic_pkg::*;
(
  input  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask_i,
  input  logic                            any_active_i,
  input  logic [LVL_W-1:0]                top_lvl_i,
  output logic                            win_valid_o,
  output logic [SRC_W-1:0]                win_src_o,
  output logic [LVL_W-1:0]                win_lvl_o
);
  logic [NUM_LVL-1:0]            elig;
  logic [NUM_LVL-1:0][SRC_W-1:0] pick;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic found;
    lic_rank_pick u_pick (
      .mask_i  (lvl_mask_i[l]),
      .found_o (found),
      .src_o   (pick[l])
    );
    assign elig[l] = found & (~any_active_i | (LVL_W'(l) > top_lvl_i));
  end

  always_comb begin
    win_valid_o = 1'b0;
    win_src_o   = '0;
    win_lvl_o   = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (elig[l]) begin
        win_valid_o = 1'b1;
        win_src_o   = pick[l];
        win_lvl_o   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/lic_inservice.sv
module lic_inservice
  import lic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic [LVL_W-1:0]   set_lvl_i,
  input  logic               reti_i,
  output logic [NUM_LVL-1:0] active_o,
  output logic               any_active_o,
  output logic [LVL_W-1:0]   top_lvl_o
);
  logic [NUM_LVL-1:0] act_q;
  logic [NUM_LVL-1:0] clr_mask;
  logic [NUM_LVL-1:0] set_mask;

  always_comb begin
    top_lvl_o = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (act_q[l]) top_lvl_o = LVL_W'(l);
  end

  assign any_active_o = |act_q;
  assign clr_mask = (reti_i && any_active_o) ? (NUM_LVL'(1) << top_lvl_o) : '0;
  assign set_mask = set_i ? (NUM_LVL'(1) << set_lvl_i) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q & ~clr_mask) | set_mask;
  end

  assign active_o = act_q;
endmodule

// File: rtl/lvl4_irq_ctrl.sv
module lvl4_irq_ctrl
  import lic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic               ser_tx_i,
  input  logic               ser_rx_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               glob_en_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic [NUM_SRC-1:0] prio_lo_i,
  output logic               irq_valid_o,
  input  logic               irq_ready_i,
  output logic [SRC_W-1:0]   irq_src_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic [NUM_SRC-1:0] ack_o,
  input  logic               reti_i,
  output logic [NUM_LVL-1:0] active_o,
  output logic               wake_o
);
  logic [NUM_SRC-1:0]              req_eff;
  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask;
  logic                            any_active;
  logic [LVL_W-1:0]                top_lvl;
  logic                            win_valid;
  logic [SRC_W-1:0]                win_src;
  logic [LVL_W-1:0]                win_lvl;
  logic                            valid_q;
  logic [SRC_W-1:0]                src_q;
  logic [LVL_W-1:0]                lvl_q;
  logic                            fire;

  always_comb begin
    req_eff             = flag_i;
    req_eff[SERIAL_SRC] = ser_tx_i | ser_rx_i;
  end

  assign wake_o = |(req_eff & en_i & WAKE_MASK);

  lic_src_level u_lvl (
    .req_i      (req_eff),
    .en_i       (en_i),
    .glob_en_i  (glob_en_i),
    .prio_hi_i  (prio_hi_i),
    .prio_lo_i  (prio_lo_i),
    .lvl_mask_o (lvl_mask)
  );

  lic_level_arb u_arb (
    .lvl_mask_i   (lvl_mask),
    .any_active_i (any_active),
    .top_lvl_i    (top_lvl),
    .win_valid_o  (win_valid),
    .win_src_o    (win_src),
    .win_lvl_o    (win_lvl)
  );

  assign fire = valid_q & irq_ready_i;

  // offer register: load only when empty, drop for a cycle after transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      lvl_q   <= '0;
    end else if (fire) begin
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      valid_q <= win_valid;
      src_q   <= win_src;
      lvl_q   <= win_lvl;
    end
  end

  lic_inservice u_isr (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (fire),
    .set_lvl_i    (lvl_q),
    .reti_i       (reti_i),
    .active_o     (active_o),
    .any_active_o (any_active),
    .top_lvl_o    (top_lvl)
  );

  assign irq_valid_o = valid_q;
  assign irq_src_o   = src_q;
  assign irq_lvl_o   = lvl_q;
  assign irq_vec_o   = vector_of(src_q);
  assign ack_o       = fire ? (NUM_SRC'(1) << src_q) : '0;
endmodule

// File: rtl/lvl4_irq_ctrl_chk.sv
module lvl4_irq_ctrl_chk
  import lic_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_valid_o,
  input logic               irq_ready_i,
  input logic [SRC_W-1:0]   irq_src_o,
  input logic [LVL_W-1:0]   irq_lvl_o,
  input logic [VEC_W-1:0]   irq_vec_o,
  input logic [NUM_SRC-1:0] ack_o,
  input logic               reti_i,
  input logic [NUM_LVL-1:0] active_o
);
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && !irq_ready_i |=> irq_valid_o && $stable(irq_src_o) && $stable(irq_vec_o) && $stable(irq_lvl_o));

  p_ack_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_ready_i |-> $countones(ack_o) == 1);

  p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid_o && irq_ready_i) |-> ack_o == '0);

  p_drop_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_ready_i |=> !irq_valid_o);

  p_level_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && irq_ready_i |=> active_o[$past(irq_lvl_o)]);

  p_offer_above_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid_o) |-> (active_o >> irq_lvl_o) == '0);

  p_reti_pops_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i && !(irq_valid_o && irq_ready_i) && active_o != '0
      |=> $countones(active_o) + 1 == $countones($past(active_o)));
endmodule

bind lvl4_irq_ctrl lvl4_irq_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_valid_o (irq_valid_o),
  .irq_ready_i (irq_ready_i),
  .irq_src_o   (irq_src_o),
  .irq_lvl_o   (irq_lvl_o),
  .irq_vec_o   (irq_vec_o),
  .ack_o       (ack_o),
  .reti_i      (reti_i),
  .active_o    (active_o)
);

// File: tb/lvl4_irq_ctrl_tb_top.sv
module lvl4_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] flag_i = '0;
  logic        ser_tx_i = 1'b0;
  logic        ser_rx_i = 1'b0;
  logic [11:0] en_i = '0;
  logic        glob_en_i = 1'b0;
  logic [11:0] prio_hi_i = '0;
  logic [11:0] prio_lo_i = '0;
  logic        irq_ready_i = 1'b0;
  logic        reti_i = 1'b0;
  logic        irq_valid_o;
  logic [3:0]  irq_src_o;
  logic [1:0]  irq_lvl_o;
  logic [15:0] irq_vec_o;
  logic [11:0] ack_o;
  logic [3:0]  active_o;
  logic        wake_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl4_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .ser_tx_i(ser_tx_i), .ser_rx_i(ser_rx_i),
    .en_i(en_i), .glob_en_i(glob_en_i), .prio_hi_i(prio_hi_i), .prio_lo_i(prio_lo_i),
    .irq_valid_o(irq_valid_o), .irq_ready_i(irq_ready_i), .irq_src_o(irq_src_o),
    .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o), .ack_o(ack_o), .reti_i(reti_i),
    .active_o(active_o), .wake_o(wake_o)
  );

  function automatic int exp_vec(input int s);
    if (s <= 8) return 3 + 8 * s;
    if (s == 9) return 'h53;
    if (s == 10) return 'h63;
    return 'h73;
  endfunction

  function automatic int rank_pos(input int s);
    case (s)
      0: return 0;  5: return 1;  9: return 2;  1: return 3;
      6: return 4;  2: return 5;  7: return 6; 10: return 7;
      3: return 8;  8: return 9;  4: return 10; default: return 11;
    endcase
  endfunction

  function automatic bit can_wake(input int s);
    return (s == 0 || s == 2 || s == 5 || s == 7 || s == 8 || s == 9 || s == 10);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_lvl(input int s, input int l);
    prio_hi_i[s] = l[1];
    prio_lo_i[s] = l[0];
  endtask

  task automatic raise(input int s);
    if (s == 4) ser_tx_i = 1'b1;
    else flag_i[s] = 1'b1;
  endtask

  task automatic clear_flags();
    flag_i = '0;
    ser_tx_i = 1'b0;
    ser_rx_i = 1'b0;
  endtask

  task automatic expect_offer(input int s, input int l, input string req);
    check(irq_valid_o == 1'b1, req, irq_valid_o, 1);
    check(irq_src_o == 4'(s), req, irq_src_o, s);
    check(irq_lvl_o == 2'(l), req, irq_lvl_o, l);
    check(irq_vec_o == 16'(exp_vec(s)), "R5", irq_vec_o, exp_vec(s));
  endtask

  // accept the held offer; checks ack and level marking
  task automatic accept(input int s, input int exp_active);
    irq_ready_i = 1'b1;
    #2;
    check(ack_o == 12'(1 << s), "R7", ack_o, 1 << s);
    tick();
    irq_ready_i = 1'b0;
    check(irq_valid_o == 1'b0, "R7", irq_valid_o, 0);
    check(active_o == 4'(exp_active), "R7", active_o, exp_active);
    check(ack_o == '0, "R7", ack_o, 0);
  endtask

  task automatic do_reti(input int exp_active);
    reti_i = 1'b1;
    tick();
    reti_i = 1'b0;
    check(active_o == 4'(exp_active), "R8", active_o, exp_active);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check(irq_valid_o == 1'b0, "R1", irq_valid_o, 0);
    check(active_o == '0, "R1", active_o, 0);
    check(ack_o == '0, "R1", ack_o, 0);
    rst_n = 1'b1;
    tick();
    check(irq_valid_o == 1'b0, "R1", irq_valid_o, 0);

    // R3 R5 R6 R7 R8: every source at every level alone
    en_i = '1;
    glob_en_i = 1'b1;
    for (int s = 0; s < 12; s++) begin
      for (int l = 0; l < 4; l++) begin
        set_lvl(s, l);
        raise(s);
        tick();
        expect_offer(s, l, "R6");
        accept(s, 1 << l);
        clear_flags();
        do_reti(0);
      end
    end

    // R4: every pair at a shared level
    prio_hi_i = '0; prio_lo_i = '1;
    for (int a = 0; a < 12; a++) begin
      for (int b = a + 1; b < 12; b++) begin
        int w;
        w = (rank_pos(a) < rank_pos(b)) ? a : b;
        raise(a); raise(b);
        tick();
        expect_offer(w, 1, "R4");
        accept(w, 2);
        tick();
        check(irq_valid_o == 1'b0, "R3", irq_valid_o, 0);
        clear_flags();
        do_reti(0);
      end
    end

    // R3: every pair at differing levels
    for (int a = 0; a < 12; a++) begin
      for (int b = a + 1; b < 12; b++) begin
        int la, lb, w, lw;
        la = a % 4;
        lb = (b * 3 + 1) % 4;
        set_lvl(a, la); set_lvl(b, lb);
        if (la > lb) w = a;
        else if (lb > la) w = b;
        else w = (rank_pos(a) < rank_pos(b)) ? a : b;
        lw = (w == a) ? la : lb;
        raise(a); raise(b);
        tick();
        expect_offer(w, lw, "R3");
        accept(w, 1 << lw);
        clear_flags();
        do_reti(0);
      end
    end

    // R3 R8: nesting and strictly-higher preemption
    set_lvl(1, 1); set_lvl(2, 1);
    raise(1); tick();
    expect_offer(1, 1, "R3");
    accept(1, 'b0010);
    clear_flags();
    raise(2); tick(); tick();
    check(irq_valid_o == 1'b0, "R3", irq_valid_o, 0);
    set_lvl(2, 2); tick();
    expect_offer(2, 2, "R3");
    accept(2, 'b0110);
    clear_flags();
    set_lvl(0, 3); raise(0); tick();
    expect_offer(0, 3, "R3");
    accept(0, 'b1110);
    clear_flags();
    set_lvl(5, 3); raise(5); tick(); tick();
    check(irq_valid_o == 1'b0, "R3", irq_valid_o, 0);
    clear_flags();
    do_reti('b0110);
    do_reti('b0010);
    // R8: accept and return in the same cycle
    set_lvl(3, 2); raise(3); tick();
    expect_offer(3, 2, "R8");
    irq_ready_i = 1'b1; reti_i = 1'b1;
    tick();
    irq_ready_i = 1'b0; reti_i = 1'b0;
    check(active_o == 4'b0100, "R8", active_o, 'b0100);
    clear_flags();
    do_reti(0);
    do_reti(0);

    // R6: held offer stays frozen under a higher newcomer
    set_lvl(11, 0); raise(11); tick();
    expect_offer(11, 0, "R6");
    set_lvl(0, 3); raise(0);
    for (int k = 0; k < 3; k++) begin
      tick();
      expect_offer(11, 0, "R6");
    end
    accept(11, 'b0001);
    flag_i[11] = 1'b0;
    tick();
    expect_offer(0, 3, "R6");
    accept(0, 'b1001);
    clear_flags();
    do_reti('b0001);
    do_reti(0);

    // R2: own enable and global enable gate arbitration
    set_lvl(7, 1);
    en_i[7] = 1'b0; raise(7); tick(); tick();
    check(irq_valid_o == 1'b0, "R2", irq_valid_o, 0);
    en_i[7] = 1'b1; glob_en_i = 1'b0; tick(); tick();
    check(irq_valid_o == 1'b0, "R2", irq_valid_o, 0);
    glob_en_i = 1'b1; tick();
    expect_offer(7, 1, "R2");
    accept(7, 'b0010);
    clear_flags();
    do_reti(0);

    // R9: serial source is tx OR rx, flag bit 4 ignored
    set_lvl(4, 0);
    flag_i[4] = 1'b1; tick(); tick();
    check(irq_valid_o == 1'b0, "R9", irq_valid_o, 0);
    check(wake_o == 1'b0, "R9", wake_o, 0);
    ser_rx_i = 1'b1; tick();
    expect_offer(4, 0, "R9");
    accept(4, 'b0001);
    clear_flags();
    do_reti(0);
    ser_tx_i = 1'b1; tick();
    expect_offer(4, 0, "R9");
    accept(4, 'b0001);
    clear_flags();
    do_reti(0);

    // R10: wakeup per source, independent of global enable
    glob_en_i = 1'b0;
    for (int s = 0; s < 12; s++) begin
      raise(s);
      #1;
      check(wake_o == can_wake(s), "R10", wake_o, can_wake(s));
      en_i[s] = 1'b0;
      #1;
      check(wake_o == 1'b0, "R10", wake_o, 0);
      en_i[s] = 1'b1;
      clear_flags();
      #1;
    end
    tick();
    check(irq_valid_o == 1'b0, "R2", irq_valid_o, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule